// File: doc/BRIEF.md
# Runtime-Programmable Sparse Matrix Stream Decoder

This block sits between memory fetch and a compressed-map encoder in a matrix-vector engine. It reads up to three first-word-fall-through FIFO streams: nonzero values on stream 0, column metadata on stream 1 and row metadata on stream 2. For every matrix element it accepts, it produces the value and a linear sequence number `row * cols + column`. A set of descriptor inputs, captured when a job starts, selects how row and column coordinates are recovered. The same logic therefore decodes dense, coordinate-list, row-pointer, padded fixed-width and diagonal-relative layouts without any change to the hardware.

Row recovery has three variants. In fixed-length mode the row comes from a counter over data-stream elements, so a divider is never needed. In direct-address mode the row stream carries the row of each element. In pointer mode the row stream carries the end pointer of each row, and a row counter steps past every pointer already reached. The column is the column-stream value, or the position within the row when there is no column stream, plus an offset. That offset is a fixed pivot, or the current row when the pivot field is all ones. In fixed-length mode a programmable pad token marks filler slots, which are dropped. The job ends once the programmed number of outputs has been produced.

Top module: `sfd_decoder`

## Requirements
- R1: `out_data` is the stream-0 value popped for that element. The column base is the stream-1 head when `cfg_col_en` is 1. Otherwise it is the position within the row in fixed-length mode, and 0 in the other modes. Stream 1 is popped together with stream 0 whenever `cfg_col_en` is 1.
- R2: With `cfg_fixed` = 1 the row equals (number of stream-0 elements already consumed in this job) / `cfg_k`, and the position within the row is the remainder. Pad elements count toward both.
- R3: With `cfg_fixed` = 0 and `cfg_row_direct` = 1, the row is the stream-2 head, and stream 2 is popped with every stream-0 element.
- R4: With `cfg_fixed` = 0 and `cfg_row_direct` = 0, the stream-2 entries are end pointers of rows 0, 1, 2 and so on (the count of nonzeros before the next row). While the head is not greater than the number of outputs already produced, one cycle pops only stream 2 and advances the row by one. Empty rows are passed over this way.
- R5: The column is the column base plus `cfg_pivot`, modulo 2^16. When `cfg_pivot` is 16'hFFFF the column is the column base plus the current row instead.
- R6: `out_seq` = row * `cfg_cols` + column, modulo 2^32. `out_valid`, `out_data` and `out_seq` are registered and appear in the cycle after the pop.
- R7: With `cfg_fixed` = 1 and `cfg_pad_en` = 1, a stream-0 element equal to `cfg_pad` is popped, together with its column entry, but produces no output and does not count toward `cfg_nnz`.
- R8: No stream is popped while its `empty` is high. An element is consumed only when every stream the mode needs is non-empty, and the block waits with no output otherwise.
- R9: After `cfg_nnz` outputs, `busy` falls and `done` rises in the same cycle as the last `out_valid`. With `cfg_nnz` = 0, `done` rises in the cycle after `start` and no output is produced.
- R10: The descriptors are captured on an accepted `start`. A `start` while `busy` is high is ignored, and changes to the descriptor inputs during a job have no effect.
- R11: After reset, `busy`, `done`, `out_valid` and all pops are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job with the current descriptors |
| cfg_cols | input | 16 | Matrix column count used in the sequence number |
| cfg_nnz | input | 16 | Number of outputs in the job |
| cfg_k | input | 16 | Elements per row in fixed-length mode |
| cfg_pad | input | 32 | Pad token value |
| cfg_pad_en | input | 1 | Enable pad stripping (fixed-length mode only) |
| cfg_pivot | input | 16 | Column offset; all ones selects the current row |
| cfg_fixed | input | 1 | Rows derived from the data-element count |
| cfg_row_direct | input | 1 | Row stream holds row addresses (1) or end pointers (0) |
| cfg_col_en | input | 1 | Column stream present |
| s0_empty | input | 1 | Data stream empty |
| s0_head | input | 32 | Data stream head value |
| s0_pop | output | 1 | Data stream pop |
| s1_empty | input | 1 | Column stream empty |
| s1_head | input | 16 | Column stream head value |
| s1_pop | output | 1 | Column stream pop |
| s2_empty | input | 1 | Row stream empty |
| s2_head | input | 16 | Row stream head value |
| s2_pop | output | 1 | Row stream pop |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job finished |
| out_valid | output | 1 | Output element valid |
| out_data | output | 32 | Element value |
| out_seq | output | 32 | Linear sequence number |

## Verification
Several rules are checked on every cycle. No stream is popped while empty, the column stream moves in step with the data stream, the row stream moves with every element in direct-address mode, and a pad pop is never followed by an output. Every output is preceded by a data pop, and the number of outputs seen at the rising edge of `done` equals the captured count. The coordinate arithmetic can only be shown by the bench. It encodes small generated matrices in every layout, compares each value and sequence number against row-major positions worked out arithmetically, and repeats this under random stream starvation and with a mid-job `start`. The same holds for empty-row skipping in pointer mode and for the zero-count job.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  parameter int unsigned SFD_IDX_W  = 16;
  parameter int unsigned SFD_DATA_W = 32;
  localparam int unsigned SFD_SEQ_W = 2 * SFD_IDX_W;

  typedef logic [SFD_IDX_W-1:0]  idx_t;
  typedef logic [SFD_DATA_W-1:0] data_t;
  typedef logic [SFD_SEQ_W-1:0]  seq_t;

  // pivot code meaning "offset by the current row"
  localparam idx_t PIVOT_ROW = '1;

  function automatic idx_t col_of(idx_t base, idx_t row, idx_t pivot);
    idx_t off;
    off = (pivot == PIVOT_ROW) ? row : pivot;
    return idx_t'(base + off);
  endfunction

  function automatic seq_t seq_of(idx_t row, idx_t col, idx_t cols);
    return seq_t'(seq_t'(row) * seq_t'(cols) + seq_t'(col));
  endfunction

  // advance a within-row position; k of 0 behaves as 1
  function automatic logic pos_wraps(idx_t pos, idx_t k);
    return (SFD_IDX_W'(pos + 1'b1) >= k) || (pos == '1);
  endfunction
endpackage

// File: rtl/sfd_fixed_rows.sv
module sfd_fixed_rows import sfd_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  idx_t k,
  output idx_t pos,
  output idx_t row
);
  idx_t pos_q, row_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pos_q <= '0;
      row_q <= '0;
    end else if (step) begin
      if (pos_wraps(pos_q, k)) begin
        pos_q <= '0;
        row_q <= row_q + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign pos = pos_q;
  assign row = row_q;
endmodule

// File: rtl/sfd_ptr_rows.sv
module sfd_ptr_rows import sfd_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output idx_t row
);
  idx_t row_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) row_q <= '0;
    else if (step)       row_q <= row_q + 1'b1;
  end

  assign row = row_q;
endmodule

// File: rtl/sfd_out_stage.sv
module sfd_out_stage import sfd_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  emit,
  input  data_t value,
  input  idx_t  row,
  input  idx_t  col_base,
  input  idx_t  pivot,
  input  idx_t  cols,
  output logic  out_valid,
  output data_t out_data,
  output seq_t  out_seq
);
  idx_t col;
  seq_t seq;

  always_comb begin
    col = col_of(col_base, row, pivot);
    seq = seq_of(row, col, cols);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_seq   <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_data <= value;
        out_seq  <= seq;
      end
    end
  end
endmodule

// File: rtl/sfd_decoder.sv
module sfd_decoder import sfd_pkg::*; (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [SFD_IDX_W-1:0]  cfg_cols,
  input  logic [SFD_IDX_W-1:0]  cfg_nnz,
  input  logic [SFD_IDX_W-1:0]  cfg_k,
  input  logic [SFD_DATA_W-1:0] cfg_pad,
  input  logic                  cfg_pad_en,
  input  logic [SFD_IDX_W-1:0]  cfg_pivot,
  input  logic                  cfg_fixed,
  input  logic                  cfg_row_direct,
  input  logic                  cfg_col_en,
  input  logic                  s0_empty,
  input  logic [SFD_DATA_W-1:0] s0_head,
  output logic                  s0_pop,
  input  logic                  s1_empty,
  input  logic [SFD_IDX_W-1:0]  s1_head,
  output logic                  s1_pop,
  input  logic                  s2_empty,
  input  logic [SFD_IDX_W-1:0]  s2_head,
  output logic                  s2_pop,
  output logic                  busy,
  output logic                  done,
  output logic                  out_valid,
  output logic [SFD_DATA_W-1:0] out_data,
  output logic [SFD_SEQ_W-1:0]  out_seq
);
  // captured descriptors
  idx_t  cols_q, nnz_q, k_q, pivot_q;
  data_t pad_q;
  logic  pad_en_q, fixed_q, direct_q, col_en_q;

  logic  busy_q, done_q;
  idx_t  emit_cnt_q;

  // named internal events
  logic  ev_accept, ev_skip, ev_fire, ev_pad, ev_emit, ev_last;
  logic  ptr_mode, ptr_ahead, streams_ok;
  idx_t  fx_pos, fx_row, pt_row, cur_row, col_base;

  assign ev_accept = start && !busy_q;

  always_comb begin
    ptr_mode   = !fixed_q && !direct_q;
    ptr_ahead  = ptr_mode && !s2_empty && (s2_head <= emit_cnt_q);
    ev_skip    = busy_q && ptr_ahead;
    streams_ok = !s0_empty && (!col_en_q || !s1_empty) && (fixed_q || !s2_empty);
    ev_fire    = busy_q && streams_ok && !ptr_ahead;
    ev_pad     = ev_fire && fixed_q && pad_en_q && (s0_head == pad_q);
    ev_emit    = ev_fire && !ev_pad;
    ev_last    = ev_emit && (idx_t'(emit_cnt_q + 1'b1) == nnz_q);
  end

  always_comb begin
    if (fixed_q)       cur_row = fx_row;
    else if (direct_q) cur_row = s2_head;
    else               cur_row = pt_row;
    if (col_en_q)      col_base = s1_head;
    else if (fixed_q)  col_base = fx_pos;
    else               col_base = '0;
  end

  assign s0_pop = ev_fire;
  assign s1_pop = ev_fire && col_en_q;
  assign s2_pop = (ev_fire && !fixed_q && direct_q) || ev_skip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cols_q   <= '0;
      nnz_q    <= '0;
      k_q      <= '0;
      pivot_q  <= '0;
      pad_q    <= '0;
      pad_en_q <= 1'b0;
      fixed_q  <= 1'b0;
      direct_q <= 1'b0;
      col_en_q <= 1'b0;
    end else if (ev_accept) begin
      cols_q   <= cfg_cols;
      nnz_q    <= cfg_nnz;
      k_q      <= cfg_k;
      pivot_q  <= cfg_pivot;
      pad_q    <= cfg_pad;
      pad_en_q <= cfg_pad_en;
      fixed_q  <= cfg_fixed;
      direct_q <= cfg_row_direct;
      col_en_q <= cfg_col_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      emit_cnt_q <= '0;
    end else if (ev_accept) begin
      busy_q     <= (cfg_nnz != '0);
      done_q     <= (cfg_nnz == '0);
      emit_cnt_q <= '0;
    end else begin
      if (ev_emit) emit_cnt_q <= emit_cnt_q + 1'b1;
      if (ev_last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  sfd_fixed_rows u_fixed (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ev_accept),
    .step  (ev_fire && fixed_q),
    .k     (k_q),
    .pos   (fx_pos),
    .row   (fx_row)
  );

  sfd_ptr_rows u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ev_accept),
    .step  (ev_skip),
    .row   (pt_row)
  );

  sfd_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .emit      (ev_emit),
    .value     (s0_head),
    .row       (cur_row),
    .col_base  (col_base),
    .pivot     (pivot_q),
    .cols      (cols_q),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_seq   (out_seq)
  );

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/sfd_decoder_chk.sv
module sfd_decoder_chk import sfd_pkg::*; (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input idx_t cfg_nnz,
  input logic s0_empty,
  input logic s0_pop,
  input logic s1_empty,
  input logic s1_pop,
  input logic s2_empty,
  input logic s2_pop,
  input logic out_valid,
  input logic ev_pad,
  input logic col_en_q,
  input logic fixed_q,
  input logic direct_q
);
  idx_t out_cnt, nnz_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_cnt <= '0;
      nnz_l   <= '0;
    end else if (start && !busy) begin
      out_cnt <= '0;
      nnz_l   <= cfg_nnz;
    end else if (out_valid) begin
      out_cnt <= out_cnt + 1'b1;
    end
  end

  a_r8_no_pop_s0_empty: assert property (@(posedge clk) disable iff (!rst_n)
    s0_pop |-> !s0_empty);
  a_r8_no_pop_s1_empty: assert property (@(posedge clk) disable iff (!rst_n)
    s1_pop |-> !s1_empty);
  a_r8_no_pop_s2_empty: assert property (@(posedge clk) disable iff (!rst_n)
    s2_pop |-> !s2_empty);
  a_r1_col_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_pop && col_en_q) |-> s1_pop);
  a_r3_row_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_pop && !fixed_q && direct_q) |-> s2_pop);
  a_r7_pad_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pad |=> !out_valid);
  a_r6_out_follows_pop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s0_pop));
  a_r9_count_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (idx_t'(out_cnt + idx_t'(out_valid)) == nnz_l));
  a_r11_idle_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(s0_pop || s1_pop || s2_pop));
endmodule

bind sfd_decoder sfd_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .cfg_nnz   (cfg_nnz),
  .s0_empty  (s0_empty),
  .s0_pop    (s0_pop),
  .s1_empty  (s1_empty),
  .s1_pop    (s1_pop),
  .s2_empty  (s2_empty),
  .s2_pop    (s2_pop),
  .out_valid (out_valid),
  .ev_pad    (ev_pad),
  .col_en_q  (col_en_q),
  .fixed_q   (fixed_q),
  .direct_q  (direct_q)
);

// File: tb/sfd_decoder_tb.sv
module sfd_decoder_tb;
  import sfd_pkg::*;

  localparam int NR = 4;
  localparam int NC = 5;
  localparam int MAXS = 64;
  localparam logic [31:0] PAD = 32'hDEAD_0001;

  localparam int F_DENSE = 0, F_COO = 1, F_CSR = 2, F_ELL = 3, F_DIA = 4, F_PIV = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start = 1'b0;
  logic [15:0] cfg_cols = '0, cfg_nnz = '0, cfg_k = '0, cfg_pivot = '0;
  logic [31:0] cfg_pad = '0;
  logic        cfg_pad_en = 1'b0, cfg_fixed = 1'b0, cfg_row_direct = 1'b0, cfg_col_en = 1'b0;
  logic        s0_empty, s1_empty, s2_empty, s0_pop, s1_pop, s2_pop;
  logic [31:0] s0_head;
  logic [15:0] s1_head, s2_head;
  logic        busy, done, out_valid;
  logic [31:0] out_data, out_seq;

  logic [31:0] s0_mem [MAXS];
  logic [15:0] s1_mem [MAXS];
  logic [15:0] s2_mem [MAXS];
  int s0_len = 0, s1_len = 0, s2_len = 0;
  int i0 = 0, i1 = 0, i2 = 0;
  logic rewind = 1'b0, thr_on = 1'b0, block_all = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  assign s0_empty = (i0 >= s0_len) || block_all || (thr_on && lfsr[0]);
  assign s1_empty = (i1 >= s1_len) || block_all || (thr_on && lfsr[5]);
  assign s2_empty = (i2 >= s2_len) || block_all || (thr_on && lfsr[9]);
  assign s0_head = (i0 < MAXS) ? s0_mem[i0] : 32'h0;
  assign s1_head = (i1 < MAXS) ? s1_mem[i1] : 16'h0;
  assign s2_head = (i2 < MAXS) ? s2_mem[i2] : 16'h0;

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst_n || rewind) begin
      i0 <= 0; i1 <= 0; i2 <= 0;
    end else begin
      if (s0_pop) i0 <= i0 + 1;
      if (s1_pop) i1 <= i1 + 1;
      if (s2_pop) i2 <= i2 + 1;
    end
  end

  sfd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_cols(cfg_cols), .cfg_nnz(cfg_nnz), .cfg_k(cfg_k), .cfg_pad(cfg_pad),
    .cfg_pad_en(cfg_pad_en), .cfg_pivot(cfg_pivot), .cfg_fixed(cfg_fixed),
    .cfg_row_direct(cfg_row_direct), .cfg_col_en(cfg_col_en),
    .s0_empty(s0_empty), .s0_head(s0_head), .s0_pop(s0_pop),
    .s1_empty(s1_empty), .s1_head(s1_head), .s1_pop(s1_pop),
    .s2_empty(s2_empty), .s2_head(s2_head), .s2_pop(s2_pop),
    .busy(busy), .done(done), .out_valid(out_valid),
    .out_data(out_data), .out_seq(out_seq)
  );

  // capture outputs away from the active edge
  logic [31:0] cap_val [256];
  logic [31:0] cap_seq [256];
  int cap_n = 0;
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      cap_val[cap_n % 256] = out_data;
      cap_seq[cap_n % 256] = out_seq;
      cap_n = cap_n + 1;
    end
  end

  int n_checks = 0, n_fail = 0;
  int cycles = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  int mat [NR][NC];
  int exp_val [MAXS];
  int exp_seq [MAXS];
  int exp_n;

  task automatic build(input int seed);
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        int h;
        h = (seed * 13 + r * 7 + c * 11 + r * c * 3) % 7;
        mat[r][c] = (h < 3 && seed != 0) ? 100 + seed * 50 + r * 10 + c : 0;
        if (seed % 2 == 1 && r == 2) mat[r][c] = 0;
      end
  endtask

  function automatic int row_nz(input int r);
    int n = 0;
    for (int c = 0; c < NC; c++) if (mat[r][c] != 0) n++;
    return n;
  endfunction

  task automatic encode(input int fmt);
    int kmax, p;
    kmax = 1;
    for (int r = 0; r < NR; r++) if (row_nz(r) > kmax) kmax = row_nz(r);
    s0_len = 0; s1_len = 0; s2_len = 0; exp_n = 0;
    cfg_cols = 16'(NC); cfg_pad = PAD; cfg_pivot = 16'h0;
    cfg_fixed = 1'b0; cfg_row_direct = 1'b0; cfg_col_en = 1'b1; cfg_pad_en = 1'b0;
    cfg_k = 16'(kmax);
    for (int r = 0; r < NR; r++) begin
      p = 0;
      for (int c = 0; c < NC; c++) begin
        if (fmt == F_DENSE || mat[r][c] != 0) begin
          exp_val[exp_n] = mat[r][c];
          exp_seq[exp_n] = r * NC + c;
          exp_n++;
        end
        if (fmt == F_DENSE) begin
          s0_mem[s0_len++] = 32'(mat[r][c]);
        end else if (mat[r][c] != 0) begin
          s0_mem[s0_len++] = 32'(mat[r][c]);
          case (fmt)
            F_DIA:   s1_mem[s1_len++] = 16'(c - r);
            F_PIV:   s1_mem[s1_len++] = 16'(c - 2);
            default: s1_mem[s1_len++] = 16'(c);
          endcase
          if (fmt == F_COO) s2_mem[s2_len++] = 16'(r);
          p++;
        end
      end
      if (fmt == F_ELL || fmt == F_DIA || fmt == F_PIV)
        for (int q = p; q < kmax; q++) begin
          s0_mem[s0_len++] = PAD;
          s1_mem[s1_len++] = 16'h0;
        end
      if (fmt == F_CSR) s2_mem[s2_len++] = 16'(exp_n);
    end
    cfg_nnz = 16'(exp_n);
    case (fmt)
      F_DENSE: begin cfg_fixed = 1'b1; cfg_col_en = 1'b0; cfg_k = 16'(NC); end
      F_COO:   cfg_row_direct = 1'b1;
      F_ELL:   begin cfg_fixed = 1'b1; cfg_pad_en = 1'b1; end
      F_DIA:   begin cfg_fixed = 1'b1; cfg_pad_en = 1'b1; cfg_pivot = 16'hFFFF; end
      F_PIV:   begin cfg_fixed = 1'b1; cfg_pad_en = 1'b1; cfg_pivot = 16'd2; end
      default: ;
    endcase
  endtask

  function automatic string tag(input int fmt);
    case (fmt)
      F_DENSE: return "R2";
      F_COO:   return "R3";
      F_CSR:   return "R4";
      F_ELL:   return "R7";
      default: return "R5";
    endcase
  endfunction

  // mode 0 plain, 1 throttled with ignored start, 2 all streams held empty first
  task automatic run_job(input int fmt, input int seed, input int mode);
    int base, waited;
    build(seed);
    encode(fmt);
    @(negedge clk); rewind = 1'b1;
    @(negedge clk); rewind = 1'b0;
    thr_on = (mode == 1);
    block_all = (mode == 2);
    base = cap_n;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (mode == 2) begin
      for (int w = 0; w < 10; w++) begin
        @(negedge clk);
        if (out_valid || !busy) check("R8", "output while starved", out_valid, 0);
      end
      check("R8", "no output while starved", cap_n - base, 0);
      block_all = 1'b0;
    end
    if (mode == 1) begin
      @(negedge clk);
      @(negedge clk);
      if (busy) begin
        cfg_nnz = 16'd1; cfg_cols = 16'd9;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
      end
    end
    waited = 0;
    while (!done && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    check("R9", "done reached", done, 1);
    check("R9", "last output with done", out_valid, (exp_n > 0) ? 1 : 0);
    check("R9", "busy low at done", busy, 0);
    @(negedge clk);
    check(mode == 1 ? "R10" : "R9", "output count", cap_n - base, exp_n);
    for (int e = 0; e < exp_n && e < cap_n - base; e++) begin
      check("R1", "value", cap_val[(base + e) % 256], exp_val[e]);
      check(tag(fmt), "seq", cap_seq[(base + e) % 256], exp_seq[e]);
    end
    if (fmt == F_COO || fmt == F_DENSE)
      check("R1", "data stream drained", i0, s0_len);
    if (fmt == F_COO) check("R3", "row stream drained", i2, s2_len);
    if (fmt == F_COO || fmt == F_CSR) check("R1", "column stream drained", i1, s1_len);
    thr_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "busy in reset", busy, 0);
    check("R11", "done in reset", done, 0);
    check("R11", "out_valid in reset", out_valid, 0);
    check("R11", "pops in reset", {s0_pop, s1_pop, s2_pop}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "idle after reset", {busy, done, out_valid, s0_pop}, 0);

    // zero-count job
    run_job(F_COO, 0, 0);

    // sweep every layout over several matrices
    for (int s = 1; s <= 4; s++)
      for (int f = F_DENSE; f <= F_PIV; f++)
        run_job(f, s, 0);

    // starvation and ignored start
    for (int f = F_DENSE; f <= F_PIV; f++) run_job(f, 3, 1);
    for (int f = F_COO; f <= F_DIA; f++) run_job(f, 2, 2);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule